// File: doc/BRIEF.md
# Output Compare Waveform Channel

This block is one compare channel of a general-purpose timer. It watches a counter value supplied from outside, compares it against an internal compare register, and drives a waveform pin from one of eight output modes. The modes cover holding the level, setting, clearing or toggling it on a match, forcing either level, and two complementary pulse-width senses. A polarity bit inverts the mode result, so the pin can be active-high or active-low.

The compare register can be written directly or through a shadow register. With the shadow in use, a new value waits until one of three commit events: an update event caused by counter overflow while updates are enabled, a match against the value currently in force, or a software compare-generate strobe. A match sets a sticky flag with its own interrupt enable; the flag is cleared by writing 1. The block can also export its waveform and a one-cycle compare trigger pulse to other logic on the chip, each behind its own enable.

The counter, input capture and the register bus are outside this block. Every input is sampled on the rising clock edge, and every output is a register.

Top module: `ocw_unit`

## Requirements
- R1: With `rst` high at a clock edge, after that edge `wave_out`, `match_flag`, `irq`, `trig_exp` and `pwm_exp` are 0 and `cmp_cur` is 0.
- R2: Mode codes on `mode_sel` (3 bits): 0 keeps the reference level unchanged, 1 sets it to active on a match, 2 sets it to inactive on a match, 3 inverts it on a match.
- R3: Mode 4 drives the reference inactive and mode 5 drives it active from the next clock edge on, whatever the counter value.
- R4: Mode 6 makes the reference active while `cnt_val` < `cmp_cur` and inactive otherwise; mode 7 makes it inactive while `cnt_val` < `cmp_cur` and active otherwise.
- R5: `wave_out` equals the reference when `pol_low` is 0 and its inverse when `pol_low` is 1; while `chan_en` is 0 the reference is forced inactive, so `wave_out` equals `pol_low` one edge later.
- R6: A match occurs in a cycle where `chan_en`, `cnt_tick` and `cnt_val == cmp_cur` all hold; `match_flag` goes to 1 at the clock edge that ends that cycle.
- R7: `flag_clr` (write 1 to clear) drops `match_flag` at the next edge, but a match in the same cycle keeps it at 1; `irq` is 1 exactly when `match_flag` is 1 and `match_ie` was 1 in the cycle that produced it.
- R8: With `preload_en` at 0, a write on `cmp_wr` puts `cmp_wdata` into `cmp_cur` at the next edge.
- R9: With `preload_en` at 1, a write goes to the shadow only; `cmp_cur` takes the shadow value at the edge after a match, a `sw_gen` strobe, or an `upd_evt` with both `upd_en` and `upd_ovf_src` at 1. A write in the same cycle as a commit reaches the shadow only; the commit uses the previous shadow value.
- R10: `trig_exp` pulses for one cycle after a match or a `sw_gen` strobe when `trig_exp_en` is 1, and stays 0 otherwise; `pwm_exp` follows `wave_out` when `pwm_exp_en` is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_en | input | 1 | Channel enable |
| cnt_tick | input | 1 | Counter advanced this cycle |
| cnt_val | input | CNT_W | Counter value |
| upd_evt | input | 1 | Timer update event |
| upd_en | input | 1 | Update events allowed |
| upd_ovf_src | input | 1 | Update event came from counter overflow |
| sw_gen | input | 1 | Software compare-generate strobe |
| mode_sel | input | 3 | Output mode, 0..7 |
| pol_low | input | 1 | 1 = active-low output |
| preload_en | input | 1 | Compare writes go through the shadow |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | CNT_W | Compare write data |
| match_ie | input | 1 | Match interrupt enable |
| flag_clr | input | 1 | Write-1 clear of the match flag |
| pwm_exp_en | input | 1 | Export waveform enable |
| trig_exp_en | input | 1 | Export trigger enable |
| wave_out | output | 1 | Waveform pin |
| match_flag | output | 1 | Sticky match flag |
| irq | output | 1 | Match interrupt |
| trig_exp | output | 1 | Exported compare trigger pulse |
| pwm_exp | output | 1 | Exported waveform |
| cmp_cur | output | CNT_W | Compare value in force |

## Verification
Two pairs of functions can fall in one cycle. A match can coincide with a write-1 clear of the flag: the bench drives `flag_clr` together with a counter value equal to the compare value and expects the flag to remain set, then clears it with no match and expects 0. A preload commit can coincide with a compare write: the bench strobes `sw_gen` in the same cycle as `cmp_wr` and expects `cmp_cur` to keep the previously shadowed value until a second strobe brings in the new one.

// File: rtl/ocw_pkg.sv
package ocw_pkg;
  typedef enum logic [2:0] {
    OCM_HOLD   = 3'd0,
    OCM_SET    = 3'd1,
    OCM_CLR    = 3'd2,
    OCM_FLIP   = 3'd3,
    OCM_FRC_LO = 3'd4,
    OCM_FRC_HI = 3'd5,
    OCM_PWM_LT = 3'd6,
    OCM_PWM_GE = 3'd7
  } ocm_e;
endpackage

// File: rtl/ocw_cmpreg.sv
module ocw_cmpreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         preload_en,
  input  logic         commit,
  output logic [W-1:0] act_q
);
  logic [W-1:0] shd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      if (wr) shd_q <= wdata;
      if (wr && !preload_en)
        act_q <= wdata;
      else if (preload_en && commit)
        act_q <= shd_q;
    end
  end
endmodule

// File: rtl/ocw_refgen.sv
module ocw_refgen
  import ocw_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [2:0]   mode,
  input  logic         hit,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  output logic         ref_nxt
);
  logic ref_q;
  logic below;
  ocm_e m;

  assign m     = ocm_e'(mode);
  assign below = (cnt < cmp);

  always_comb begin
    ref_nxt = ref_q;
    if (!en) begin
      ref_nxt = 1'b0;
    end else begin
      unique case (m)
        OCM_HOLD:   ref_nxt = ref_q;
        OCM_SET:    if (hit) ref_nxt = 1'b1;
        OCM_CLR:    if (hit) ref_nxt = 1'b0;
        OCM_FLIP:   if (hit) ref_nxt = !ref_q;
        OCM_FRC_LO: ref_nxt = 1'b0;
        OCM_FRC_HI: ref_nxt = 1'b1;
        OCM_PWM_LT: ref_nxt = below;
        OCM_PWM_GE: ref_nxt = !below;
        default:    ref_nxt = ref_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ref_q <= 1'b0;
    else     ref_q <= ref_nxt;
  end
endmodule

// File: rtl/ocw_events.sv
module ocw_events (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic sw_gen,
  input  logic flag_clr,
  input  logic ie,
  input  logic trig_en,
  output logic flag_q,
  output logic irq_q,
  output logic trig_q
);
  logic flag_nxt;

  // A set in the same cycle as a clear wins.
  assign flag_nxt = hit | (flag_q & ~flag_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      irq_q  <= flag_nxt & ie;
      trig_q <= trig_en & (hit | sw_gen);
    end
  end
endmodule

// File: rtl/ocw_unit.sv
module ocw_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_en,
  input  logic             cnt_tick,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             upd_evt,
  input  logic             upd_en,
  input  logic             upd_ovf_src,
  input  logic             sw_gen,
  input  logic [2:0]       mode_sel,
  input  logic             pol_low,
  input  logic             preload_en,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             match_ie,
  input  logic             flag_clr,
  input  logic             pwm_exp_en,
  input  logic             trig_exp_en,
  output logic             wave_out,
  output logic             match_flag,
  output logic             irq,
  output logic             trig_exp,
  output logic             pwm_exp,
  output logic [CNT_W-1:0] cmp_cur
);
  logic hit;
  logic upd_commit;
  logic commit;
  logic ref_nxt;
  logic wave_nxt;

  assign hit        = chan_en & cnt_tick & (cnt_val == cmp_cur);
  assign upd_commit = upd_evt & upd_en & upd_ovf_src;
  assign commit     = hit | sw_gen | upd_commit;

  ocw_cmpreg #(.W(CNT_W)) u_cmp (
    .clk        (clk),
    .rst        (rst),
    .wr         (cmp_wr),
    .wdata      (cmp_wdata),
    .preload_en (preload_en),
    .commit     (commit),
    .act_q      (cmp_cur)
  );

  ocw_refgen #(.W(CNT_W)) u_ref (
    .clk     (clk),
    .rst     (rst),
    .en      (chan_en),
    .mode    (mode_sel),
    .hit     (hit),
    .cnt     (cnt_val),
    .cmp     (cmp_cur),
    .ref_nxt (ref_nxt)
  );

  ocw_events u_evt (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .sw_gen   (sw_gen),
    .flag_clr (flag_clr),
    .ie       (match_ie),
    .trig_en  (trig_exp_en),
    .flag_q   (match_flag),
    .irq_q    (irq),
    .trig_q   (trig_exp)
  );

  // Polarity applies after the mode logic; a disabled channel gives 0 from refgen.
  assign wave_nxt = ref_nxt ^ pol_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_out <= 1'b0;
      pwm_exp  <= 1'b0;
    end else begin
      wave_out <= wave_nxt;
      pwm_exp  <= wave_nxt & pwm_exp_en;
    end
  end
endmodule

// File: rtl/ocw_unit_chk.sv
module ocw_unit_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             chan_en,
  input logic             cnt_tick,
  input logic [CNT_W-1:0] cnt_val,
  input logic             upd_evt,
  input logic             upd_en,
  input logic             upd_ovf_src,
  input logic             sw_gen,
  input logic [2:0]       mode_sel,
  input logic             pol_low,
  input logic             preload_en,
  input logic             cmp_wr,
  input logic [CNT_W-1:0] cmp_wdata,
  input logic             trig_exp_en,
  input logic             wave_out,
  input logic             match_flag,
  input logic             irq,
  input logic             trig_exp,
  input logic [CNT_W-1:0] cmp_cur
);
  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_en && cnt_tick && cnt_val == cmp_cur) |=> match_flag);

  // R7
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> match_flag);

  // R5
  off_level_chk: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> (wave_out == $past(pol_low)));

  // R3
  force_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_en && mode_sel == 3'd5) |=> (wave_out == !$past(pol_low)));

  // R8
  direct_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_wr && !preload_en) |=> (cmp_cur == $past(cmp_wdata)));

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (preload_en && !sw_gen && !(upd_evt && upd_en && upd_ovf_src)
      && !(chan_en && cnt_tick && cnt_val == cmp_cur)) |=> $stable(cmp_cur));

  // R10
  trig_off_chk: assert property (@(posedge clk) disable iff (rst)
    !trig_exp_en |=> !trig_exp);
endmodule

bind ocw_unit ocw_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .chan_en     (chan_en),
  .cnt_tick    (cnt_tick),
  .cnt_val     (cnt_val),
  .upd_evt     (upd_evt),
  .upd_en      (upd_en),
  .upd_ovf_src (upd_ovf_src),
  .sw_gen      (sw_gen),
  .mode_sel    (mode_sel),
  .pol_low     (pol_low),
  .preload_en  (preload_en),
  .cmp_wr      (cmp_wr),
  .cmp_wdata   (cmp_wdata),
  .trig_exp_en (trig_exp_en),
  .wave_out    (wave_out),
  .match_flag  (match_flag),
  .irq         (irq),
  .trig_exp    (trig_exp),
  .cmp_cur     (cmp_cur)
);

// File: tb/ocw_unit_test.sv
module ocw_unit_test;
  localparam int W = 16;
  localparam int S_WAVE = 0, S_FLAG = 1, S_IRQ = 2, S_TRIG = 3, S_PWM = 4, S_CMP = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chan_en = 0, cnt_tick = 0, upd_evt = 0, upd_en = 0, upd_ovf_src = 0, sw_gen = 0;
  logic [W-1:0] cnt_val = '0, cmp_wdata = '0;
  logic [2:0] mode_sel = 3'd0;
  logic pol_low = 0, preload_en = 0, cmp_wr = 0, match_ie = 0, flag_clr = 0;
  logic pwm_exp_en = 0, trig_exp_en = 0;
  logic wave_out, match_flag, irq, trig_exp, pwm_exp;
  logic [W-1:0] cmp_cur;

  typedef struct {
    int          sig;
    logic [31:0] val;
    string       tag;
  } item_t;
  item_t sb[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ocw_unit #(.CNT_W(W)) uut (
    .clk(clk), .rst(rst), .chan_en(chan_en), .cnt_tick(cnt_tick), .cnt_val(cnt_val),
    .upd_evt(upd_evt), .upd_en(upd_en), .upd_ovf_src(upd_ovf_src), .sw_gen(sw_gen),
    .mode_sel(mode_sel), .pol_low(pol_low), .preload_en(preload_en), .cmp_wr(cmp_wr),
    .cmp_wdata(cmp_wdata), .match_ie(match_ie), .flag_clr(flag_clr),
    .pwm_exp_en(pwm_exp_en), .trig_exp_en(trig_exp_en), .wave_out(wave_out),
    .match_flag(match_flag), .irq(irq), .trig_exp(trig_exp), .pwm_exp(pwm_exp),
    .cmp_cur(cmp_cur)
  );

  function automatic logic [31:0] observe(int sig);
    case (sig)
      S_WAVE:  return 32'(wave_out);
      S_FLAG:  return 32'(match_flag);
      S_IRQ:   return 32'(irq);
      S_TRIG:  return 32'(trig_exp);
      S_PWM:   return 32'(pwm_exp);
      default: return 32'(cmp_cur);
    endcase
  endfunction

  // Driver side: expected item for the coming clock edge.
  task automatic expect_at(int sig, logic [31:0] val, string tag);
    item_t it;
    it.sig = sig; it.val = val; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
    cmp_wr = 0; sw_gen = 0; flag_clr = 0; upd_evt = 0;
  endtask

  // Monitor: compares after each edge, away from it.
  always @(posedge clk) begin
    #1;
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it  = sb.pop_front();
      got = observe(it.sig);
      checks++;
      if (got !== it.val) begin
        errors++;
        $display("FAIL %s signal %0d: got %0h expected %0h", it.tag, it.sig, got, it.val);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    step();
    expect_at(S_WAVE, 0, "R1"); expect_at(S_FLAG, 0, "R1"); expect_at(S_IRQ, 0, "R1");
    expect_at(S_TRIG, 0, "R1"); expect_at(S_PWM, 0, "R1"); expect_at(S_CMP, 0, "R1");
    step();
    rst = 0;

    // R8 direct write
    cmp_wr = 1; cmp_wdata = 10; expect_at(S_CMP, 10, "R8"); step();

    // R6 no match off the compare value, then no match without a tick
    chan_en = 1; mode_sel = 3'd1; cnt_tick = 1; cnt_val = 5; trig_exp_en = 1;
    expect_at(S_WAVE, 0, "R6"); expect_at(S_FLAG, 0, "R6"); expect_at(S_TRIG, 0, "R6"); step();
    cnt_val = 10; cnt_tick = 0;
    expect_at(S_WAVE, 0, "R6"); expect_at(S_FLAG, 0, "R6"); step();
    // R2 set on match, R6 flag, R10 trigger
    cnt_tick = 1;
    expect_at(S_WAVE, 1, "R2"); expect_at(S_FLAG, 1, "R6"); expect_at(S_TRIG, 1, "R10");
    expect_at(S_IRQ, 0, "R7"); step();
    cnt_val = 11;
    expect_at(S_WAVE, 1, "R2"); expect_at(S_FLAG, 1, "R6"); expect_at(S_TRIG, 0, "R10"); step();
    // R7 clear, irq, set wins over clear
    flag_clr = 1; expect_at(S_FLAG, 0, "R7"); step();
    match_ie = 1; cnt_val = 10;
    expect_at(S_FLAG, 1, "R7"); expect_at(S_IRQ, 1, "R7"); step();
    flag_clr = 1; expect_at(S_FLAG, 1, "R7 set wins"); step();
    cnt_val = 11; flag_clr = 1;
    expect_at(S_FLAG, 0, "R7"); expect_at(S_IRQ, 0, "R7"); step();

    // R2 clear and toggle
    mode_sel = 3'd2; cnt_val = 10; expect_at(S_WAVE, 0, "R2"); step();
    mode_sel = 3'd3; expect_at(S_WAVE, 1, "R2"); step();
    expect_at(S_WAVE, 0, "R2"); step();
    // R3 force active, R2 frozen holds
    mode_sel = 3'd5; cnt_val = 3; expect_at(S_WAVE, 1, "R3"); step();
    mode_sel = 3'd0; cnt_val = 10;
    expect_at(S_WAVE, 1, "R2"); expect_at(S_FLAG, 1, "R2"); step();
    mode_sel = 3'd4; cnt_val = 3; expect_at(S_WAVE, 0, "R3"); step();
    // R5 polarity
    pol_low = 1; expect_at(S_WAVE, 1, "R5"); step();
    mode_sel = 3'd5; expect_at(S_WAVE, 0, "R5"); step();
    // R5 disabled channel drives the inactive level
    chan_en = 0; expect_at(S_WAVE, 1, "R5"); step();
    pol_low = 0; expect_at(S_WAVE, 0, "R5"); step();
    cnt_val = 11; flag_clr = 1; expect_at(S_FLAG, 0, "R7"); step();
    cnt_val = 10; expect_at(S_FLAG, 0, "R6"); expect_at(S_TRIG, 0, "R6"); step();

    // R4 PWM senses, R10 waveform export
    chan_en = 1; mode_sel = 3'd6; pwm_exp_en = 1; cnt_val = 3;
    expect_at(S_WAVE, 1, "R4"); expect_at(S_PWM, 1, "R10"); step();
    cnt_val = 10; expect_at(S_WAVE, 0, "R4"); expect_at(S_PWM, 0, "R10"); step();
    cnt_val = 12; expect_at(S_WAVE, 0, "R4"); step();
    mode_sel = 3'd7; expect_at(S_WAVE, 1, "R4"); expect_at(S_PWM, 1, "R10"); step();
    cnt_val = 3; expect_at(S_WAVE, 0, "R4"); step();
    pwm_exp_en = 0; cnt_val = 12;
    expect_at(S_WAVE, 1, "R4"); expect_at(S_PWM, 0, "R10"); step();

    // R9 preload and its three commit events
    mode_sel = 3'd1; cnt_val = 3; preload_en = 1; cmp_wr = 1; cmp_wdata = 20;
    expect_at(S_CMP, 10, "R9"); step();
    sw_gen = 1; expect_at(S_CMP, 20, "R9"); expect_at(S_TRIG, 1, "R10"); step();
    cmp_wr = 1; cmp_wdata = 30; expect_at(S_CMP, 20, "R9"); step();
    upd_evt = 1; upd_en = 0; upd_ovf_src = 1; expect_at(S_CMP, 20, "R9"); step();
    upd_evt = 1; upd_en = 1; upd_ovf_src = 0; expect_at(S_CMP, 20, "R9"); step();
    upd_evt = 1; upd_ovf_src = 1; expect_at(S_CMP, 30, "R9"); step();
    cmp_wr = 1; cmp_wdata = 40; expect_at(S_CMP, 30, "R9"); step();
    cnt_val = 30;
    expect_at(S_CMP, 40, "R9"); expect_at(S_FLAG, 1, "R6"); expect_at(S_TRIG, 1, "R10"); step();
    cnt_val = 3; cmp_wr = 1; cmp_wdata = 50; sw_gen = 1;
    expect_at(S_CMP, 40, "R9 same cycle"); step();
    sw_gen = 1; expect_at(S_CMP, 50, "R9"); step();

    step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule